// File: doc/BRIEF.md
# Dual Microsecond Interval Timer

This block contains two independent interval timers that share one microsecond time base. A prescaler divides the system clock into a single-cycle tick once per microsecond. On each tick, each timer's 21-bit count register moves up by one. When the next count would reach or pass the programmed limit, the count goes back to 1 rather than 0 and a sticky limit flag is set. A limit word of L therefore gives a period of L-1 microseconds. Software wanting a period of N microseconds programs N+1.

Each timer drives its own interrupt line, and the line follows that timer's flag. Timer 0 is meant for the lower of two priority levels and timer 1 for the higher. Software services an interrupt by reading that timer's count register, which returns the flag and count and then clears the flag. Programming a new limit restarts the timer from 1. All registers are 32-bit words on a simple single-cycle read/write bus. Read data appears one clock after the request.

Top module: `dual_usec_timer`

## Requirements
- R1: After reset, both counts are 1, both limits are 0x1FFFFF, both flags and both interrupts are low, and `bus_rdata` is zero.
- R2: Word select uses `bus_addr[3:2]`: 0 is count 0, 1 is limit 0, 2 is count 1, 3 is limit 1. `bus_addr[1:0]` is ignored. Read data is registered on the clock edge that accepts the read and holds until the next read.
- R3: A count read returns the flag in bit 31, the count in bits 30:10 and zeros in bits 9:0. A limit read returns zero in bit 31, the limit in bits 30:10 and zeros in bits 9:0.
- R4: The tick is one clock wide and occurs once every `CLK_PER_US` clocks. The first tick comes on the `CLK_PER_US`-th edge after reset is released. Counts change only on a tick or on a limit write.
- R5: On a tick, if count+1 is at least the limit, the count becomes 1 and the flag is set. Otherwise the count becomes count+1. A limit of 4 gives 1,2,3,1,2,3. A limit of 0 or 1 reloads on every tick.
- R6: The flag is sticky: once set, it stays set until a count read or a limit write of the same timer. `irq_t0` follows timer 0's flag and `irq_t1` follows timer 1's flag.
- R7: A count read returns the flag value from before the read. It then clears that timer's flag, so the interrupt is low in the following cycle.
- R8: If a count read happens in the same cycle as a reload of that timer, the flag stays set.
- R9: A limit write loads `bus_wdata[30:10]` into the limit, sets the count to 1 and clears the flag. Bits 31 and 9:0 of the written word are ignored. The write takes priority over a tick in the same cycle.
- R10: Writes to a count register have no effect.
- R11: The two timers are independent: bus access and reloads of one never change the other's count, limit, flag or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_t0 | output | 1 | Interrupt of timer 0 (lower priority) |
| irq_t1 | output | 1 | Interrupt of timer 1 (higher priority) |

## Verification
A wrong count, limit or flag inside either timer appears on `irq_t0` or `irq_t1` at the next reload. That is at most one period late, since the interrupt is the flag register itself. It also appears in `bus_rdata` one clock after any read of that timer. The bench compares both interrupts and the read data against a behavioural model on every clock. A divergence is therefore caught on the first clock in which it becomes visible. The stimulus also repeats reads and limit writes across a whole prescaler period, so that each coincides with a tick at least once.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int CNT_W    = 21;
  localparam int CNT_LSB  = 10;
  localparam int FLAG_BIT = DATA_W - 1;
  localparam int NUM_TMR  = 2;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef struct packed {
    logic             flag;
    logic [CNT_W-1:0] value;
    logic [CNT_LSB-1:0] zero;
  } tmr_word_t;

  function automatic logic [DATA_W-1:0] pack_word(input logic flag,
                                                  input logic [CNT_W-1:0] value);
    tmr_word_t w;
    w.flag  = flag;
    w.value = value;
    w.zero  = '0;
    return w;
  endfunction
endpackage

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PC_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [PC_W-1:0] pc_q;
      logic            wrap;
      assign wrap   = (pc_q == PC_W'(DIV - 1));
      assign tick_o = wrap;

      always_ff @(posedge clk) begin
        if (rst)       pc_q <= '0;
        else if (wrap) pc_q <= '0;
        else           pc_q <= pc_q + PC_W'(1);
      end

      p_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
      p_pc_bound_r4: assert property (@(posedge clk) disable iff (rst)
        pc_q <= PC_W'(DIV - 1));
    end else begin : g_pass
      assign tick_o = !rst;
    end
  endgenerate
endmodule

// File: rtl/interval_unit.sv
module interval_unit
  import usec_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] lim_wdata,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lim_q,
  output logic             flag_q
);
  logic [CNT_W:0] cnt_inc;
  logic           hit;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign hit     = tick && (cnt_inc >= {1'b0, lim_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_ONE;
      lim_q  <= CNT_MAX;
      flag_q <= 1'b0;
    end else if (lim_wr) begin
      lim_q  <= lim_wdata;
      cnt_q  <= CNT_ONE;
      flag_q <= 1'b0;
    end else begin
      if (hit)       cnt_q <= CNT_ONE;
      else if (tick) cnt_q <= cnt_inc[CNT_W-1:0];
      if (hit)         flag_q <= 1'b1;
      else if (rd_clr) flag_q <= 1'b0;
    end
  end

  p_cnt_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0);
  p_cnt_below_lim_r5: assert property (@(posedge clk) disable iff (rst)
    (lim_q > CNT_ONE) |-> (cnt_q < lim_q));
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && !lim_wr) |=> (cnt_q == CNT_ONE) && flag_q);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !lim_wr) |=> $stable(cnt_q) && $stable(lim_q));
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd_clr && !lim_wr) |=> flag_q);
  p_rdclr_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !hit && !lim_wr) |=> !flag_q);
  p_race_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && hit && !lim_wr) |=> flag_q);
  p_limwr_r9: assert property (@(posedge clk) disable iff (rst)
    lim_wr |=> (cnt_q == CNT_ONE) && !flag_q && (lim_q == $past(lim_wdata)));
endmodule

// File: rtl/dual_usec_timer.sv
module dual_usec_timer
  import usec_timer_pkg::*;
#(
  parameter int CLK_PER_US = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_t0,
  output logic              irq_t1
);
  logic             tick;
  logic             rd_req, wr_req, is_lim, tsel;
  logic [CNT_W-1:0] cnt_a  [NUM_TMR];
  logic [CNT_W-1:0] lim_a  [NUM_TMR];
  logic             flag_a [NUM_TMR];
  logic [DATA_W-1:0] rd_word;
  logic             unused_bits;

  assign rd_req = bus_sel && !bus_we;
  assign wr_req = bus_sel && bus_we;
  assign tsel   = bus_addr[3];
  assign is_lim = bus_addr[2];
  assign unused_bits = ^{bus_wdata[FLAG_BIT], bus_wdata[CNT_LSB-1:0], bus_addr[1:0]};

  usec_tick_gen #(.DIV(CLK_PER_US)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      logic hit_sel;
      assign hit_sel = (tsel == 1'(i));
      interval_unit u_unit (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .lim_wr    (wr_req && is_lim && hit_sel),
        .lim_wdata (bus_wdata[CNT_LSB +: CNT_W]),
        .rd_clr    (rd_req && !is_lim && hit_sel),
        .cnt_q     (cnt_a[i]),
        .lim_q     (lim_a[i]),
        .flag_q    (flag_a[i])
      );
    end
  endgenerate

  always_comb begin
    if (is_lim) rd_word = pack_word(1'b0, lim_a[tsel]);
    else        rd_word = pack_word(flag_a[tsel], cnt_a[tsel]);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_word;
  end

  assign irq_t0 = flag_a[0];
  assign irq_t1 = flag_a[1];

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(bus_rdata));
  p_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[CNT_LSB-1:0] == '0);
  p_lim_msb_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && is_lim) |=> !bus_rdata[FLAG_BIT]);
  p_cnt_wr_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !is_lim && !tick) |=> $stable(cnt_a[0]) && $stable(cnt_a[1]));
endmodule

// File: tb/sim_dual_usec_timer.sv
module sim_dual_usec_timer;
  localparam int DIV = 5;
  localparam int WDOG = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_t0, irq_t1;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  dual_usec_timer #(.CLK_PER_US(DIV)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_t0(irq_t0), .irq_t1(irq_t1)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int unsigned m_pc, m_cnt[2], m_lim[2];
  bit          m_flag[2], m_tick, m_ev, m_rd, m_wr;
  logic [31:0] m_rdata;
  int          m_idx;

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_rdata = 0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 1; m_lim[i] = 32'h1FFFFF; m_flag[i] = 0; end
    end else begin
      m_tick = (m_pc == DIV - 1);
      m_pc   = m_tick ? 0 : m_pc + 1;
      m_rd   = bus_sel && !bus_we;
      m_wr   = bus_sel && bus_we;
      m_idx  = bus_addr[3] ? 1 : 0;
      if (m_rd) begin
        if (bus_addr[2]) m_rdata = m_lim[m_idx] * 1024;
        else m_rdata = (m_flag[m_idx] ? 32'h8000_0000 : 32'h0) | (m_cnt[m_idx] * 1024);
      end
      for (int i = 0; i < 2; i++) begin
        if (m_wr && bus_addr[2] && m_idx == i) begin
          m_lim[i] = (bus_wdata >> 10) & 32'h1FFFFF; m_cnt[i] = 1; m_flag[i] = 0;
        end else begin
          m_ev = m_tick && (m_cnt[i] + 1 >= m_lim[i]);
          if (m_ev) m_cnt[i] = 1; else if (m_tick) m_cnt[i] = m_cnt[i] + 1;
          if (m_ev) m_flag[i] = 1;
          else if (m_rd && !bus_addr[2] && m_idx == i) m_flag[i] = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk({cur_req, " rdata"}, bus_rdata, m_rdata);
    chk({cur_req, " irq_t0"}, {31'b0, irq_t0}, {31'b0, m_flag[0]});
    chk({cur_req, " irq_t1"}, {31'b0, irq_t1}, {31'b0, m_flag[1]});
  endtask

  task automatic step(input bit s, input bit w, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 4'h0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    chk("R1 irq in reset", {30'b0, irq_t1, irq_t0}, 32'h0);
    @(negedge clk);
    rst = 1'b0; bus_sel = 1; bus_we = 0; bus_addr = 4'h0;   // read count 0
    step(1, 0, 4'h5, 32'h0);                                 // R2: addr[1:0] ignored, limit 0
    chk("R1 R3 count0 after reset", bus_rdata, 32'h0000_0400);
    step(1, 0, 4'hE, 32'h0);                                 // limit 1
    chk("R1 R3 limit0 after reset", bus_rdata, 32'h7FFF_FC00);
    step(0, 0, 4'h0, 32'h0);
    chk("R1 R2 limit1 after reset", bus_rdata, 32'h7FFF_FC00);
    cur_req = "R4"; idle(23);
    step(1, 0, 4'h8, 32'h0); idle(2);

    cur_req = "R9";                                          // limit 4, junk in bits 31 and 9:0
    step(1, 1, 4'h4, 32'h8000_13FF);
    step(1, 0, 4'h4, 32'h0);
    step(0, 0, 4'h0, 32'h0);
    chk("R9 limit0 readback", bus_rdata, 32'h0000_1000);

    cur_req = "R5";
    for (int i = 0; i < 40; i++) step(1, 0, 4'h1, 32'h0);   // peek count path via limit? no: count0 addr 1 -> bits[1:0] ignored
    cur_req = "R6"; idle(20);
    chk("R6 irq_t0 sticky high", {31'b0, irq_t0}, 32'h1);
    chk("R11 irq_t1 untouched", {31'b0, irq_t1}, 32'h0);
    cur_req = "R7";
    step(1, 0, 4'h0, 32'h0); idle(1);
    chk("R7 read returns flag", {31'b0, bus_rdata[31]}, 32'h1);
    idle(3);

    cur_req = "R8";
    step(1, 1, 4'h4, 32'h0000_0400);                         // limit 1: reload every tick
    for (int i = 0; i < 3 * DIV; i++) step(1, 0, 4'h0, 32'h0);
    cur_req = "R9";
    step(1, 1, 4'h4, 32'h0000_0000);                         // limit 0
    idle(12);
    for (int i = 0; i < 2 * DIV; i++) step(1, 1, 4'h4, 32'h0000_1800);  // writes vs ticks
    idle(9);

    cur_req = "R10";
    step(1, 1, 4'h0, 32'hFFFF_FFFF);
    step(1, 1, 4'h8, 32'hFFFF_FFFF);
    step(1, 0, 4'h0, 32'h0);
    step(1, 0, 4'h8, 32'h0); idle(2);

    cur_req = "R11";
    step(1, 1, 4'hC, 32'h0000_0C00);                         // timer 1 limit 3
    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 3) step(1, 0, 4'h8, 32'h0);
      else if (i % 11 == 5) step(1, 0, 4'h0, 32'h0);
      else step(0, 0, 4'h0, 32'h0);
    end
    step(1, 0, 4'hC, 32'h0); idle(1);
    chk("R11 limit1 readback", bus_rdata, 32'h0000_0C00);
    step(1, 0, 4'h4, 32'h0); idle(1);
    chk("R11 limit0 unchanged", bus_rdata, 32'h0000_1800);
    idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule